// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small shared word memory used by several processors and gives them an atomic read-modify-write primitive built from two halves. A load-linked returns the addressed word and records, for the requesting processor, a reservation on that address. A later store-conditional from the same processor writes its data only while that reservation is still intact, and reports pass or fail so that software can retry the whole sequence on failure.

Requests arrive one per cycle on a single port tagged with the requester number; arbitration between processors happens upstream. Each processor owns one reservation register (a valid bit and an address). A reservation is lost when another processor writes the address, when an external invalidation or eviction names the address, when that processor's context-switch line is raised, or when its own store-conditional consumes it. Plain loads and stores pass straight through and need no reservation.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After reset every memory word reads 0, no reservation is held and `rsp_valid` is 0 until a request is accepted.
- R2: Every accepted request (`req_valid` high) produces exactly one response with `rsp_valid` high on the following cycle; a load (`req_op`=0) or load-linked (`req_op`=2) returns the word stored at `req_addr` before any write in that cycle on `rsp_rdata`.
- R3: A store-conditional (`req_op`=3) whose requester holds a valid reservation on `req_addr` writes `req_wdata` and responds with `rsp_ok`=1; `rsp_ok` is 1 for no other kind of response.
- R4: A store-conditional from a requester holding no reservation responds with `rsp_ok`=0 and leaves memory unchanged.
- R5: A store-conditional to an address other than its requester's reserved address fails and leaves memory unchanged.
- R6: Any write to an address (a plain store, `req_op`=1, or a successful store-conditional) clears the reservations that other requesters hold on that address.
- R7: An invalidation (`inval_valid` with `inval_addr`) clears every reservation on that address, including one checked by a store-conditional in the same cycle.
- R8: An eviction (`evict_valid` with `evict_addr`) clears every reservation on that address.
- R9: Raising bit k of `ctx_sw` clears the reservation of requester k, whatever its address.
- R10: A store-conditional clears its requester's reservation whether it passes or fails.
- R11: Each requester holds at most one reservation; a new load-linked replaces the previous one.
- R12: A plain store always writes, responds with `rsp_ok`=0, and does not clear the writer's own reservation.
- R13: Clearing events aimed at other addresses or other requesters leave a reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | IDW | Requesting processor number (below N_CPU) |
| req_op | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| inval_valid | input | 1 | External invalidation of one address |
| inval_addr | input | AW | Address invalidated |
| evict_valid | input | 1 | Replacement of one address |
| evict_addr | input | AW | Address evicted |
| ctx_sw | input | N_CPU | Per-processor context-switch strobe |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_ok | output | 1 | Store-conditional passed |
| rsp_rdata | output | DW | Read data for loads and load-linked |

## Verification
Every response is due exactly one clock edge after its request, and a clearing event takes effect in the same cycle it is raised, so a store-conditional issued in the next cycle (or the same one) already sees it. The bench drives each request after an edge, waits for the next edge and samples the response one nanosecond later, so the value read always belongs to that request. Memory contents are observed through a plain load issued after each store-conditional, one cycle later again.

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int N_CPU = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int IDW   = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDW-1:0]   req_id,
  input  logic [1:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             inval_valid,
  input  logic [AW-1:0]    inval_addr,
  input  logic             evict_valid,
  input  logic [AW-1:0]    evict_addr,
  input  logic [N_CPU-1:0] ctx_sw,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [DW-1:0]    rsp_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_LL = 2'd2, OP_SC = 2'd3;

  logic [DW-1:0]    mem [DEPTH];
  logic [N_CPU-1:0] resv_v, resv_v_n, kill;
  logic [AW-1:0]    resv_a   [N_CPU];
  logic [AW-1:0]    resv_a_n [N_CPU];

  logic is_sc, sc_pass, mem_we, ll_block;

  always_comb
    for (int i = 0; i < N_CPU; i++)
      kill[i] = ctx_sw[i] ||
                (inval_valid && inval_addr == resv_a[i]) ||
                (evict_valid && evict_addr == resv_a[i]);

  assign is_sc    = req_valid && req_op == OP_SC;
  assign sc_pass  = is_sc && resv_v[req_id] && resv_a[req_id] == req_addr && !kill[req_id];
  assign mem_we   = req_valid && (req_op == OP_ST || sc_pass);
  assign ll_block = (inval_valid && inval_addr == req_addr) ||
                    (evict_valid && evict_addr == req_addr);

  always_comb
    for (int i = 0; i < N_CPU; i++) begin
      resv_v_n[i] = resv_v[i];
      resv_a_n[i] = resv_a[i];
      if (req_valid && req_id == IDW'(i) && req_op == OP_LL) begin
        resv_v_n[i] = !(ctx_sw[i] || ll_block);
        resv_a_n[i] = req_addr;
      end else if (req_valid && req_id == IDW'(i) && req_op == OP_SC)
        resv_v_n[i] = 1'b0;
      else if (kill[i])
        resv_v_n[i] = 1'b0;
      else if (mem_we && req_id != IDW'(i) && resv_a[i] == req_addr)
        resv_v_n[i] = 1'b0;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resv_v <= '0;
      for (int i = 0; i < N_CPU; i++) resv_a[i] <= '0;
    end else begin
      resv_v <= resv_v_n;
      for (int i = 0; i < N_CPU; i++) resv_a[i] <= resv_a_n[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (mem_we) begin
      mem[req_addr] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= sc_pass;
      rsp_rdata <= (req_valid && (req_op == OP_LD || req_op == OP_LL)) ? mem[req_addr] : '0;
    end
  end
endmodule

module llsc_resv_chk #(
  parameter int N_CPU = 4,
  parameter int AW    = 4,
  parameter int IDW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [IDW-1:0]   req_id,
  input logic [1:0]       req_op,
  input logic [AW-1:0]    req_addr,
  input logic             inval_valid,
  input logic [AW-1:0]    inval_addr,
  input logic [N_CPU-1:0] ctx_sw,
  input logic [N_CPU-1:0] resv_v,
  input logic             rsp_valid,
  input logic             rsp_ok
);
  // R2
  resp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  ok_only_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> $past(req_valid) && $past(req_op) == 2'd3);
  // R7
  inval_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3 && inval_valid && inval_addr == req_addr) |=> !rsp_ok);
  // R9
  ctx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_sw != '0) |=> (resv_v & $past(ctx_sw)) == '0);
  // R10
  sc_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd3) |=> !resv_v[$past(req_id)]);
endmodule

bind llsc_resv_monitor llsc_resv_chk #(.N_CPU(N_CPU), .AW(AW), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_op(req_op), .req_addr(req_addr), .inval_valid(inval_valid),
  .inval_addr(inval_addr), .ctx_sw(ctx_sw), .resv_v(resv_v),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
);

// File: tb/sim_llsc_resv_monitor.sv
`timescale 1ns/1ps
module sim_llsc_resv_monitor;
  localparam int N = 4, AW = 4, DW = 16, IDW = 2;
  localparam logic [1:0] LD = 0, ST = 1, LL = 2, SC = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, inval_valid = 0, evict_valid = 0;
  logic [IDW-1:0] req_id = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0, inval_addr = 0, evict_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [N-1:0] ctx_sw = 0;
  logic rsp_valid, rsp_ok;
  logic [DW-1:0] rsp_rdata;
  logic g_v, g_ok;
  logic [DW-1:0] g_d;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  llsc_resv_monitor #(.N_CPU(N), .AW(AW), .DW(DW)) u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int id, input logic [1:0] op, input int a, input int wd,
                     input bit rq = 1, input bit iv = 0, input int ia = 0,
                     input bit ev = 0, input int ea = 0, input logic [N-1:0] cs = '0);
    req_valid = rq; req_id = IDW'(id); req_op = op; req_addr = AW'(a); req_wdata = DW'(wd);
    inval_valid = iv; inval_addr = AW'(ia); evict_valid = ev; evict_addr = AW'(ea); ctx_sw = cs;
    @(posedge clk); #1;
    g_v = rsp_valid; g_ok = rsp_ok; g_d = rsp_rdata;
    req_valid = 0; inval_valid = 0; evict_valid = 0; ctx_sw = '0;
  endtask

  task automatic t_reset;
    check("R1 rsp_valid idle", 32'(rsp_valid), 0);
    cyc(0, LD, 5, 0);
    check("R1 reset word", 32'(g_d), 0);
    check("R2 load valid", 32'(g_v), 1);
  endtask

  task automatic t_ll_sc;
    cyc(0, ST, 2, 'h11);
    check("R12 store ok flag", 32'(g_ok), 0);
    cyc(1, LL, 2, 0);
    check("R2 ll data", 32'(g_d), 'h11);
    cyc(1, SC, 2, 'h22);
    check("R3 sc pass", 32'(g_ok), 1);
    cyc(3, LD, 2, 0);
    check("R3 sc wrote", 32'(g_d), 'h22);
  endtask

  task automatic t_no_resv;
    cyc(2, SC, 7, 'h33);
    check("R4 sc no resv", 32'(g_ok), 0);
    cyc(2, LD, 7, 0);
    check("R4 mem kept", 32'(g_d), 0);
  endtask

  task automatic t_wrong_addr;
    cyc(2, LL, 7, 0);
    cyc(2, SC, 8, 'h44);
    check("R5 sc other addr", 32'(g_ok), 0);
    cyc(2, LD, 8, 0);
    check("R5 mem kept", 32'(g_d), 0);
  endtask

  task automatic t_sc_clears;
    cyc(3, LL, 4, 0);
    cyc(3, SC, 4, 1);
    check("R10 first sc", 32'(g_ok), 1);
    cyc(3, SC, 4, 2);
    check("R10 second sc", 32'(g_ok), 0);
    cyc(3, LD, 4, 0);
    check("R10 mem", 32'(g_d), 1);
  endtask

  task automatic t_conflict;
    cyc(0, LL, 9, 0); cyc(1, LL, 9, 0);
    cyc(2, ST, 9, 5);
    cyc(0, SC, 9, 6);
    check("R6 store kills cpu0", 32'(g_ok), 0);
    cyc(1, SC, 9, 7);
    check("R6 store kills cpu1", 32'(g_ok), 0);
    cyc(0, LL, 9, 0); cyc(1, LL, 9, 0);
    cyc(0, SC, 9, 8);
    check("R6 winner", 32'(g_ok), 1);
    cyc(1, SC, 9, 9);
    check("R6 loser", 32'(g_ok), 0);
    cyc(2, LD, 9, 0);
    check("R6 mem", 32'(g_d), 8);
  endtask

  task automatic t_own_store;
    cyc(0, LL, 10, 0);
    cyc(0, ST, 10, 7);
    cyc(0, SC, 10, 8);
    check("R12 own store keeps resv", 32'(g_ok), 1);
  endtask

  task automatic t_inval;
    cyc(1, LL, 11, 0);
    cyc(0, LD, 0, 0, 0, 1, 11);
    cyc(1, SC, 11, 3);
    check("R7 inval earlier", 32'(g_ok), 0);
    cyc(1, LL, 11, 0);
    cyc(1, SC, 11, 3, 1, 1, 11);
    check("R7 inval same cycle", 32'(g_ok), 0);
    cyc(1, LD, 11, 0);
    check("R7 mem", 32'(g_d), 0);
  endtask

  task automatic t_evict;
    cyc(2, LL, 12, 0);
    cyc(0, LD, 0, 0, 0, 0, 0, 1, 12);
    cyc(2, SC, 12, 3);
    check("R8 evict", 32'(g_ok), 0);
  endtask

  task automatic t_ctx;
    cyc(3, LL, 13, 0);
    cyc(0, LD, 0, 0, 0, 0, 0, 0, 0, 4'b1000);
    cyc(3, SC, 13, 3);
    check("R9 ctx switch", 32'(g_ok), 0);
    cyc(3, LL, 13, 0);
    cyc(0, LD, 0, 0, 0, 0, 0, 0, 0, 4'b0001);
    cyc(3, SC, 13, 3);
    check("R13 other ctx", 32'(g_ok), 1);
  endtask

  task automatic t_unrelated;
    cyc(0, LL, 14, 0);
    cyc(1, ST, 15, 2, 1, 1, 15, 1, 3);
    cyc(0, SC, 14, 6);
    check("R13 unrelated events", 32'(g_ok), 1);
    cyc(0, LD, 14, 0);
    check("R13 mem", 32'(g_d), 6);
  endtask

  task automatic t_replace;
    cyc(1, LL, 1, 0); cyc(1, LL, 2, 0);
    cyc(1, SC, 1, 5);
    check("R11 old addr", 32'(g_ok), 0);
    cyc(1, LL, 1, 0); cyc(1, LL, 2, 0);
    cyc(1, SC, 2, 5);
    check("R11 new addr", 32'(g_ok), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_ll_sc; t_no_resv; t_wrong_addr; t_sc_clears; t_conflict;
    t_own_store; t_inval; t_evict; t_ctx; t_unrelated; t_replace;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule